// File: doc/BRIEF.md
# Programmable DRAM command sequencer

This block is a small in-order engine that runs a stored program to produce DRAM command traffic. The program works on sixteen 32-bit general registers that hold bank, row and column addresses and loop counters. It can branch on an unsigned compare and can wait for an exact number of clock cycles. A command instruction issues a bundle of four DRAM command slots in one cycle. Each slot carries one of activate, precharge, read, write or no-operation. A 512-bit write-data register is filled 32 bits at a time from the general registers and drives the data that accompanies write commands.

Software writes the program through a simple load port while the engine is idle, then pulses start. The engine runs from program address 0 until it reaches an END instruction, then raises done. Command bundles appear on flat per-slot output vectors, qualified by a valid strobe. The physical DRAM interface, read-data capture and host transfer logic sit outside this block.

Every instruction is 64 bits wide. Bits [63:60] hold the opcode. Unused fields are don't-care. Registers keep their values across runs, and they and the write-data register reset to zero.

Top module: `dram_cmd_sequencer`

## Requirements
- R1: A write on the load port (`prog_we` with `prog_addr`, `prog_data`) is stored only while the engine is idle. A write while a program runs is ignored, and the running program behaves as if the write never happened.
- R2: Start, sampled while idle, clears done and begins execution at program address 0. The instruction at address k executes k+1 cycles after the start edge when no branch or sleep intervenes. Start while running is ignored.
- R3: Each instruction other than SLEEP takes exactly one cycle. A command instruction (opcode 1) puts its bundle on the outputs in the cycle after it executes, and `cmd_valid` is high only in such cycles.
- R4: Command slot k sits in instruction bits [12k+11:12k] as {kind[11:9], bank register[8:5], address register[4:1], all-banks flag[0]}. Kind 0 is NOP, 1 is ACT, 2 is PRE, 3 is READ, 4 is WRITE, and 5 to 7 act as NOP. Output slot k takes bits [3k+2:3k] of `cmd_kind`, [4k+3:4k] of `cmd_bank`, [18k+17:18k] of `cmd_addr` and bit k of `cmd_all`. A NOP slot outputs zero bank, address and flag.
- R5: The bank output is the low 4 bits of the named bank register. For ACT the address output is the low 18 bits of the named row register. For READ and WRITE it is the low 18 bits of the named column register. For PRE the address output is 0.
- R6: The all-banks flag reaches `cmd_all` only on a PRE slot, where it selects precharge of every bank. On every other kind `cmd_all` is 0.
- R7: SLEEP (opcode 2, count in [31:0]) occupies max(n,1) cycles and issues no command during them. The next instruction executes that many cycles after the SLEEP began.
- R8: Load-immediate (opcode 3) writes [31:0] into register [59:56]. Add-immediate (opcode 4) writes register [55:52] plus [31:0], modulo 2^32, into register [59:56]. Register 0 is an ordinary register.
- R9: Branch-if-less (opcode 5) compares register [59:56] with register [55:52] as unsigned numbers. When the first is smaller it jumps to program address [9:0] with no lost cycle. When equal or greater it falls through.
- R10: Load-wide-data (opcode 6) copies register [55:52] into bits [32s+31:32s] of `wdata`, where s is instruction bits [51:48]. Other slices keep their value. `wdata` changes only after such an instruction.
- R11: END (opcode 0) stops execution and raises done in the next cycle. Done stays high until the next accepted start, and no command follows END.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_we | input | 1 | Program load write enable |
| prog_addr | input | 10 | Program load address |
| prog_data | input | 64 | Program load instruction word |
| start | input | 1 | Start pulse, accepted while idle |
| done | output | 1 | Program reached END |
| cmd_valid | output | 1 | A command bundle is on the outputs this cycle |
| cmd_kind | output | 12 | Command kind per slot, 3 bits each |
| cmd_bank | output | 16 | Bank per slot, 4 bits each |
| cmd_addr | output | 72 | Row or column address per slot, 18 bits each |
| cmd_all | output | 4 | All-banks precharge flag per slot |
| wdata | output | 512 | Wide write-data register |

## Verification
On every cycle the assertions check that the outputs stay silent while the engine is idle or sleeping, and that a taken branch lands exactly on its target. They also check that the program counter steps by one otherwise, that done excludes running, and that the wide data register changes only after a load-wide instruction. In every valid bundle they check that NOP slots carry zeros and that the all-banks flag rides only on precharge. Only the bench's scenarios can show that the cycle positions, addresses and banks of whole bundles are right. The same holds for the length of a sleep, for loops that step a column register, for ignored loads and starts during a run, and for the placement of data slices.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int XLEN    = 32;
  localparam int NREG    = 16;
  localparam int RIDX_W  = 4;
  localparam int INSTR_W = 64;
  localparam int NSLOT   = 4;
  localparam int KIND_W  = 3;
  localparam int SLOT_W  = 12;

  localparam logic [3:0] OP_END   = 4'd0;
  localparam logic [3:0] OP_CMD   = 4'd1;
  localparam logic [3:0] OP_SLEEP = 4'd2;
  localparam logic [3:0] OP_LI    = 4'd3;
  localparam logic [3:0] OP_ADDI  = 4'd4;
  localparam logic [3:0] OP_BLT   = 4'd5;
  localparam logic [3:0] OP_LDWD  = 4'd6;

  localparam logic [KIND_W-1:0] K_NOP = 3'd0;
  localparam logic [KIND_W-1:0] K_ACT = 3'd1;
  localparam logic [KIND_W-1:0] K_PRE = 3'd2;
  localparam logic [KIND_W-1:0] K_RD  = 3'd3;
  localparam logic [KIND_W-1:0] K_WR  = 3'd4;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_WAIT} seq_state_e;

  typedef struct packed {
    logic [KIND_W-1:0] kind;
    logic [RIDX_W-1:0] breg;
    logic [RIDX_W-1:0] areg;
    logic              all;
  } slot_t;

  function automatic logic [3:0] f_op(input logic [INSTR_W-1:0] i);
    return i[63:60];
  endfunction

  function automatic logic [RIDX_W-1:0] f_ra(input logic [INSTR_W-1:0] i);
    return i[59:56];
  endfunction

  function automatic logic [RIDX_W-1:0] f_rb(input logic [INSTR_W-1:0] i);
    return i[55:52];
  endfunction

  function automatic logic [3:0] f_slice(input logic [INSTR_W-1:0] i);
    return i[51:48];
  endfunction

  function automatic logic [XLEN-1:0] f_imm(input logic [INSTR_W-1:0] i);
    return i[31:0];
  endfunction

  function automatic slot_t f_slot(input logic [NSLOT*SLOT_W-1:0] s, input int k);
    return slot_t'(s[k*SLOT_W +: SLOT_W]);
  endfunction

  function automatic logic [XLEN-1:0] f_add(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    return a + b;
  endfunction

  function automatic logic f_less(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    return a < b;
  endfunction

  // Cycles spent in the wait state after the SLEEP cycle itself.
  function automatic logic [XLEN-1:0] f_sleep_extra(input logic [XLEN-1:0] n);
    return (n > 1) ? n - 1 : '0;
  endfunction

  function automatic logic [KIND_W-1:0] f_kind_norm(input logic [KIND_W-1:0] k);
    return (k >= K_ACT && k <= K_WR) ? k : K_NOP;
  endfunction

  function automatic logic f_kind_has_addr(input logic [KIND_W-1:0] k);
    return (k == K_ACT) || (k == K_RD) || (k == K_WR);
  endfunction
endpackage

// File: rtl/seq_imem.sv
module seq_imem #(
  parameter int DEPTH = 1024,
  parameter int W     = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/seq_regfile.sv
module seq_regfile #(
  parameter int NREG = 16,
  parameter int XLEN = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [IW-1:0]             widx,
  input  logic [XLEN-1:0]           wval,
  output logic [NREG-1:0][XLEN-1:0] regs
);
  always_ff @(posedge clk) begin
    if (!rst_n)  regs <= '0;
    else if (we) regs[widx] <= wval;
  end
endmodule

// File: rtl/seq_wide_data.sv
module seq_wide_data #(
  parameter int SLICE_W = 32,
  parameter int NSLICE  = 16,
  localparam int IW     = $clog2(NSLICE)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ld,
  input  logic [IW-1:0]               idx,
  input  logic [SLICE_W-1:0]          val,
  output logic [NSLICE*SLICE_W-1:0]   wdata
);
  logic [NSLICE-1:0][SLICE_W-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (ld) q[idx] <= val;
  end

  assign wdata = q;
endmodule

// File: rtl/seq_cmd_bundle.sv
module seq_cmd_bundle
  import seq_pkg::*;
#(
  parameter int BANK_W = 4,
  parameter int ADDR_W = 18
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          issue,
  input  logic [NSLOT*SLOT_W-1:0]       slots,
  input  logic [NREG-1:0][BANK_W-1:0]   bank_src,
  input  logic [NREG-1:0][ADDR_W-1:0]   addr_src,
  output logic                          cmd_valid,
  output logic [NSLOT*KIND_W-1:0]       cmd_kind,
  output logic [NSLOT*BANK_W-1:0]       cmd_bank,
  output logic [NSLOT*ADDR_W-1:0]       cmd_addr,
  output logic [NSLOT-1:0]              cmd_all
);
  logic [NSLOT-1:0][KIND_W-1:0] n_kind;
  logic [NSLOT-1:0][BANK_W-1:0] n_bank;
  logic [NSLOT-1:0][ADDR_W-1:0] n_addr;
  logic [NSLOT-1:0]             n_all;

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    slot_t s;
    assign s         = f_slot(slots, k);
    assign n_kind[k] = f_kind_norm(s.kind);
    assign n_bank[k] = (n_kind[k] == K_NOP) ? '0 : bank_src[s.breg];
    assign n_addr[k] = f_kind_has_addr(n_kind[k]) ? addr_src[s.areg] : '0;
    assign n_all[k]  = (n_kind[k] == K_PRE) && s.all;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !issue) begin
      cmd_valid <= 1'b0;
      cmd_kind  <= '0;
      cmd_bank  <= '0;
      cmd_addr  <= '0;
      cmd_all   <= '0;
    end else begin
      cmd_valid <= 1'b1;
      cmd_kind  <= n_kind;
      cmd_bank  <= n_bank;
      cmd_addr  <= n_addr;
      cmd_all   <= n_all;
    end
  end
endmodule

// File: rtl/dram_cmd_sequencer.sv
module dram_cmd_sequencer
  import seq_pkg::*;
#(
  parameter int IMEM_DEPTH = 1024,
  parameter int BANK_W     = 4,
  parameter int ADDR_W     = 18,
  parameter int WIDE_W     = 512,
  localparam int PC_W      = $clog2(IMEM_DEPTH),
  localparam int NSLICE    = WIDE_W / XLEN,
  localparam int SLICE_IW  = $clog2(NSLICE)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      prog_we,
  input  logic [PC_W-1:0]           prog_addr,
  input  logic [INSTR_W-1:0]        prog_data,
  input  logic                      start,
  output logic                      done,
  output logic                      cmd_valid,
  output logic [NSLOT*KIND_W-1:0]   cmd_kind,
  output logic [NSLOT*BANK_W-1:0]   cmd_bank,
  output logic [NSLOT*ADDR_W-1:0]   cmd_addr,
  output logic [NSLOT-1:0]          cmd_all,
  output logic [WIDE_W-1:0]         wdata
);
  seq_state_e              state;
  logic [PC_W-1:0]         pc;
  logic [XLEN-1:0]         cnt;
  logic [INSTR_W-1:0]      instr;
  logic [3:0]              op;
  logic [NREG-1:0][XLEN-1:0] regs;

  // Named internal events, also used by the bound checker.
  logic            busy, sleeping, in_run;
  logic            exec_cmd, ld_wide, reg_we, br_taken, pc_step;
  logic [PC_W-1:0] br_target;
  logic [XLEN-1:0] val_a, val_b, reg_wval, sleep_extra;

  logic [NREG-1:0][BANK_W-1:0] bank_src;
  logic [NREG-1:0][ADDR_W-1:0] addr_src;

  seq_imem #(.DEPTH(IMEM_DEPTH), .W(INSTR_W)) u_imem (
    .clk   (clk),
    .we    (prog_we && !busy),
    .waddr (prog_addr),
    .wdata (prog_data),
    .raddr (pc),
    .rdata (instr)
  );

  assign op          = f_op(instr);
  assign busy        = (state != ST_IDLE);
  assign sleeping    = (state == ST_WAIT);
  assign in_run      = (state == ST_RUN);
  assign val_a       = regs[f_ra(instr)];
  assign val_b       = regs[f_rb(instr)];
  assign exec_cmd    = in_run && (op == OP_CMD);
  assign ld_wide     = in_run && (op == OP_LDWD);
  assign reg_we      = in_run && ((op == OP_LI) || (op == OP_ADDI));
  assign reg_wval    = (op == OP_LI) ? f_imm(instr) : f_add(val_b, f_imm(instr));
  assign br_taken    = in_run && (op == OP_BLT) && f_less(val_a, val_b);
  assign br_target   = instr[PC_W-1:0];
  assign pc_step     = in_run && (op != OP_END) && !br_taken;
  assign sleep_extra = f_sleep_extra(f_imm(instr));

  seq_regfile #(.NREG(NREG), .XLEN(XLEN)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_we),
    .widx  (f_ra(instr)),
    .wval  (reg_wval),
    .regs  (regs)
  );

  seq_wide_data #(.SLICE_W(XLEN), .NSLICE(NSLICE)) u_wide (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (ld_wide),
    .idx   (SLICE_IW'(f_slice(instr))),
    .val   (val_b),
    .wdata (wdata)
  );

  for (genvar r = 0; r < NREG; r++) begin : g_src
    assign bank_src[r] = regs[r][BANK_W-1:0];
    assign addr_src[r] = regs[r][ADDR_W-1:0];
  end

  seq_cmd_bundle #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_bundle (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (exec_cmd),
    .slots     (instr[NSLOT*SLOT_W-1:0]),
    .bank_src  (bank_src),
    .addr_src  (addr_src),
    .cmd_valid (cmd_valid),
    .cmd_kind  (cmd_kind),
    .cmd_bank  (cmd_bank),
    .cmd_addr  (cmd_addr),
    .cmd_all   (cmd_all)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      pc    <= '0;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_RUN;
            pc    <= '0;
            done  <= 1'b0;
          end
        end
        ST_RUN: begin
          if (op == OP_END) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else if (br_taken) begin
            pc <= br_target;
          end else begin
            pc <= pc + 1'b1;
          end
          if (op == OP_SLEEP && sleep_extra != '0) begin
            cnt   <= sleep_extra;
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          cnt <= cnt - 1'b1;
          if (cnt == 1) state <= ST_RUN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dram_cmd_sequencer_chk.sv
module dram_cmd_sequencer_chk #(
  parameter int PC_W   = 10,
  parameter int NSLOT  = 4,
  parameter int BANK_W = 4,
  parameter int ADDR_W = 18,
  parameter int WIDE_W = 512
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    busy,
  input logic                    sleeping,
  input logic                    done,
  input logic                    cmd_valid,
  input logic [NSLOT*3-1:0]      cmd_kind,
  input logic [NSLOT*BANK_W-1:0] cmd_bank,
  input logic [NSLOT*ADDR_W-1:0] cmd_addr,
  input logic [NSLOT-1:0]        cmd_all,
  input logic                    br_taken,
  input logic [PC_W-1:0]         br_target,
  input logic                    pc_step,
  input logic [PC_W-1:0]         pc,
  input logic                    ld_wide,
  input logic [WIDE_W-1:0]       wdata
);
  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !cmd_valid);

  assert_pc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pc_step |=> pc == $past(pc) + PC_W'(1));

  assert_sleep_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sleeping |=> !cmd_valid);

  assert_branch_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |=> pc == $past(br_target));

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_wide_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_wide |=> $stable(wdata));

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot_chk
    assert_nop_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_kind[3*k +: 3] == 3'd0) |->
        (cmd_bank[BANK_W*k +: BANK_W] == '0 && cmd_addr[ADDR_W*k +: ADDR_W] == '0));

    assert_all_on_pre_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_all[k] |-> (cmd_valid && cmd_kind[3*k +: 3] == 3'd2));
  end
endmodule

bind dram_cmd_sequencer dram_cmd_sequencer_chk #(
  .PC_W(PC_W), .NSLOT(seq_pkg::NSLOT), .BANK_W(BANK_W), .ADDR_W(ADDR_W), .WIDE_W(WIDE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sleeping(sleeping), .done(done),
  .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
  .cmd_all(cmd_all), .br_taken(br_taken), .br_target(br_target), .pc_step(pc_step),
  .pc(pc), .ld_wide(ld_wide), .wdata(wdata)
);

// File: tb/dram_cmd_sequencer_bench.sv
module dram_cmd_sequencer_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         prog_we = 1'b0;
  logic [9:0]   prog_addr = '0;
  logic [63:0]  prog_data = '0;
  logic         start = 1'b0;
  logic         done, cmd_valid;
  logic [11:0]  cmd_kind;
  logic [15:0]  cmd_bank;
  logic [71:0]  cmd_addr;
  logic [3:0]   cmd_all;
  logic [511:0] wdata;

  dram_cmd_sequencer u_dram_cmd_sequencer (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .start(start), .done(done), .cmd_valid(cmd_valid),
    .cmd_kind(cmd_kind), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
    .cmd_all(cmd_all), .wdata(wdata)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          at;
    string       tag;
    logic [11:0] kind;
    logic [15:0] bank;
    logic [71:0] addr;
    logic [3:0]  all;
  } bundle_t;
  bundle_t expq[$];

  // Instruction builders, following the field layout in the requirements.
  function automatic logic [63:0] i_end();
    return 64'd0;
  endfunction
  function automatic logic [63:0] i_li(input logic [3:0] rd, input logic [31:0] imm);
    return {4'd3, rd, 24'd0, imm};
  endfunction
  function automatic logic [63:0] i_addi(input logic [3:0] rd, input logic [3:0] rs, input logic [31:0] imm);
    return {4'd4, rd, rs, 20'd0, imm};
  endfunction
  function automatic logic [63:0] i_blt(input logic [3:0] a, input logic [3:0] b, input logic [15:0] t);
    return {4'd5, a, b, 36'd0, t};
  endfunction
  function automatic logic [63:0] i_sleep(input logic [31:0] n);
    return {4'd2, 28'd0, n};
  endfunction
  function automatic logic [63:0] i_ldwd(input logic [3:0] rs, input logic [3:0] s);
    return {4'd6, 4'd0, rs, s, 48'd0};
  endfunction
  function automatic logic [11:0] sl(input logic [2:0] k, input logic [3:0] b, input logic [3:0] a, input logic f);
    return {k, b, a, f};
  endfunction
  function automatic logic [63:0] i_cmd(input logic [11:0] s3, input logic [11:0] s2,
                                        input logic [11:0] s1, input logic [11:0] s0);
    return {4'd1, 12'd0, s3, s2, s1, s0};
  endfunction

  // Expected slot: {kind, bank, addr, all}
  function automatic logic [25:0] es(input logic [2:0] k, input logic [3:0] b,
                                     input logic [17:0] a, input logic f);
    return {k, b, a, f};
  endfunction
  localparam logic [25:0] ENOP = 26'd0;

  task automatic push_exp(input int at, input string tag, input logic [25:0] s0,
                          input logic [25:0] s1, input logic [25:0] s2, input logic [25:0] s3);
    bundle_t b;
    logic [25:0] s [4];
    s[0] = s0; s[1] = s1; s[2] = s2; s[3] = s3;
    b.at = at; b.tag = tag;
    for (int k = 0; k < 4; k++) begin
      b.kind[3*k +: 3]   = s[k][25:23];
      b.bank[4*k +: 4]   = s[k][22:19];
      b.addr[18*k +: 18] = s[k][18:1];
      b.all[k]           = s[k][0];
    end
    expq.push_back(b);
  endtask

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Monitor: pop and compare every bundle the design issues.
  always @(negedge clk) begin
    if (rst_n && cmd_valid) begin
      checks++;
      if (expq.size() == 0) begin
        failures++;
        $display("FAIL R3 unexpected bundle actual kind=%0h at cycle %0d expected none", cmd_kind, cyc);
      end else begin
        bundle_t e;
        e = expq.pop_front();
        if (e.at != cyc || e.kind != cmd_kind || e.bank != cmd_bank ||
            e.addr != cmd_addr || e.all != cmd_all) begin
          failures++;
          $display("FAIL %s actual cyc=%0d kind=%0h bank=%0h addr=%0h all=%0h expected cyc=%0d kind=%0h bank=%0h addr=%0h all=%0h",
                   e.tag, cyc, cmd_kind, cmd_bank, cmd_addr, cmd_all,
                   e.at, e.kind, e.bank, e.addr, e.all);
        end
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d cycles expected completion", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic load(input int a, input logic [63:0] d);
    @(negedge clk);
    prog_we = 1'b1; prog_addr = 10'(a); prog_data = d;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic run_start(output int base);
    @(negedge clk);
    base = cyc + 1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_cyc(input int t);
    while (cyc != t) @(negedge clk);
  endtask

  initial begin
    int base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R11 reset done", 64'(done), 64'd0);
    check(cmd_valid == 1'b0, "R3 reset valid", 64'(cmd_valid), 64'd0);
    check(wdata == '0, "R10 reset wdata", wdata[63:0], 64'd0);

    // Program 1: data slices, precharge-all, sleep, column loop.
    load(0,  i_li(4'd3, 32'd99));
    load(1,  i_li(4'd4, 32'd2));
    load(2,  i_li(4'd5, 32'd0));
    load(3,  i_li(4'd10, 32'd0));
    load(4,  i_li(4'd11, 32'd3));
    load(5,  i_li(4'd6, 32'hA5A5_0000));
    load(6,  i_ldwd(4'd6, 4'd0));
    load(7,  i_li(4'd6, 32'h1234_5678));
    load(8,  i_ldwd(4'd6, 4'd15));
    load(9,  i_cmd(sl(0,0,0,0), sl(0,0,0,0), sl(0,0,0,0), sl(3'd2, 4'd4, 4'd0, 1'b1)));
    load(10, i_sleep(32'd5));
    load(11, i_cmd(sl(3'd3, 4'd4, 4'd5, 1'b1), sl(0,0,0,0), sl(3'd4, 4'd4, 4'd5, 1'b0),
                   sl(3'd1, 4'd4, 4'd3, 1'b1)));
    load(12, i_addi(4'd5, 4'd5, 32'd8));
    load(13, i_addi(4'd10, 4'd10, 32'd1));
    load(14, i_blt(4'd10, 4'd11, 16'd11));
    load(15, i_sleep(32'd1));
    load(16, i_cmd(sl(3'd2, 4'd4, 4'd3, 1'b0), sl(0,0,0,0), sl(0,0,0,0), sl(0,0,0,0)));
    load(17, i_end());

    run_start(base);
    // R6 precharge-all at base+10; R5 bank from register 4
    push_exp(base + 10, "R6", es(3'd2, 4'd2, 18'd0, 1'b1), ENOP, ENOP, ENOP);
    // R7 sleep 5 then R5/R9 loop, column steps by 8; flag on READ slot dropped (R6)
    for (int i = 0; i < 3; i++)
      push_exp(base + 16 + 4*i, "R5", es(3'd1, 4'd2, 18'd99, 1'b0),
               es(3'd4, 4'd2, 18'(8*i), 1'b0), ENOP, es(3'd3, 4'd2, 18'(8*i), 1'b0));
    // R4 slot 3 single-bank precharge after sleep 1
    push_exp(base + 29, "R4", ENOP, ENOP, ENOP, es(3'd2, 4'd2, 18'd0, 1'b0));

    // R1: write during the run must be ignored
    wait_cyc(base + 12);
    prog_we = 1'b1; prog_addr = 10'd16;
    prog_data = i_cmd(sl(3'd1,4'd4,4'd3,1'b0), sl(3'd1,4'd4,4'd3,1'b0),
                      sl(3'd1,4'd4,4'd3,1'b0), sl(3'd1,4'd4,4'd3,1'b0));
    @(negedge clk);
    prog_we = 1'b0;
    // R2: start while busy must be ignored
    wait_cyc(base + 20);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;

    wait_cyc(base + 29);
    check(done == 1'b0, "R11 done before END", 64'(done), 64'd0);
    wait_cyc(base + 30);
    check(done == 1'b1, "R11 done after END", 64'(done), 64'd1);
    check(expq.size() == 0, "R3 all bundles seen", 64'(expq.size()), 64'd0);
    check(wdata[31:0] == 32'hA5A5_0000, "R10 slice 0", 64'(wdata[31:0]), 64'hA5A5_0000);
    check(wdata[511:480] == 32'h1234_5678, "R10 slice 15", 64'(wdata[511:480]), 64'h1234_5678);
    check(wdata[479:32] == '0, "R10 other slices", 64'(wdata[95:32]), 64'd0);
    repeat (5) @(negedge clk);
    check(done == 1'b1, "R11 done held", 64'(done), 64'd1);

    // Program 2: register 0, equal compare, sleep 0, wrap, taken branch.
    load(0,  i_li(4'd0, 32'd7));
    load(1,  i_li(4'd1, 32'd7));
    load(2,  i_blt(4'd0, 4'd1, 16'd5));
    load(3,  i_sleep(32'd0));
    load(4,  i_cmd(sl(0,0,0,0), sl(3'd1, 4'd1, 4'd0, 1'b0), sl(0,0,0,0), sl(3'd6, 4'd1, 4'd1, 1'b1)));
    load(5,  i_li(4'd2, 32'hFFFF_FFFF));
    load(6,  i_addi(4'd2, 4'd2, 32'd1));
    load(7,  i_blt(4'd2, 4'd1, 16'd9));
    load(8,  i_cmd(sl(0,0,0,0), sl(0,0,0,0), sl(0,0,0,0), sl(3'd2, 4'd1, 4'd1, 1'b1)));
    load(9,  i_cmd(sl(0,0,0,0), sl(0,0,0,0), sl(0,0,0,0), sl(3'd3, 4'd0, 4'd2, 1'b0)));
    load(10, i_end());

    run_start(base);
    check(done == 1'b0, "R2 done cleared by start", 64'(done), 64'd0);
    // R8 register 0 usable; R9 equal falls through; R7 sleep 0 is one cycle; kind 6 is NOP
    push_exp(base + 5, "R8", ENOP, ENOP, es(3'd1, 4'd7, 18'd7, 1'b0), ENOP);
    // R9 taken branch skips address 8 with no lost cycle; R8 add wraps to 0
    push_exp(base + 9, "R9", es(3'd3, 4'd7, 18'd0, 1'b0), ENOP, ENOP, ENOP);
    wait_cyc(base + 10);
    check(done == 1'b1, "R11 done program 2", 64'(done), 64'd1);
    check(expq.size() == 0, "R9 bundles program 2", 64'(expq.size()), 64'd0);
    check(wdata[31:0] == 32'hA5A5_0000, "R10 wdata untouched", 64'(wdata[31:0]), 64'hA5A5_0000);
    repeat (4) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule